// File: doc/BRIEF.md
# Retro Video Pixel Capture Front-End

This block records the raw digital picture of an older home computer so that it can be stored in a frame-buffer memory. The source computer provides its own pixel clock, a horizontal sync, a vertical sync and five colour/intensity bits. This block does not share a clock with that computer. Every input is sampled by a fast system clock, nominally 108 MHz. The clock and sync lines first pass through a synchronizer and a stability filter, which removes short spikes. Each filtered line then goes to an edge detector that emits a one-cycle pulse.

A falling vertical sync starts a frame and returns the line number, the column and the write address to zero. A falling horizontal sync returns the column to zero and moves the line number up by one. Each accepted rising edge of the pixel clock captures the five pixel bits and advances the column and the write address. Every three captured pixels are packed, together with the address of the first of the three, into one 31-bit word. That word is offered to an external 512-entry FIFO that feeds the memory arbiter. If the FIFO is full at that moment, the word is discarded and a sticky overflow flag is raised.

Top module: `vcap_frontend`

## Requirements
- R1: After reset, `fifo_wr`, `overflow`, `line_num` and `col_num` are all 0.
- R2: A level change on the pixel clock, horizontal sync or vertical sync input is accepted only once it has held for 3 consecutive system clocks after synchronization. A pulse of 2 system clocks or less causes no column advance and no FIFO word.
- R3: A falling edge on vertical sync sets `line_num` and `col_num` to 0 and resets the pixel address. The first word written after it carries address 0.
- R4: A falling edge on horizontal sync sets `col_num` to 0 and increments `line_num`. It also discards any partly collected group of pixels, while pixel addresses that were already used stay consumed.
- R5: Each accepted rising edge of the pixel clock increments `col_num` by 1 and the pixel address by 1. Within a frame, the pixel with index k (counting from 0) receives address k modulo 65536.
- R6: The packed word layout, from MSB to LSB, is `fifo_data[30:15]` = the address of the first pixel of the group, `[14:10]` = third pixel, `[9:5]` = second pixel, `[4:0]` = first pixel. The pixel bits are passed on exactly as they were sampled.
- R7: A completed group produces a `fifo_wr` pulse exactly one system clock long, holding that word.
- R8: If `fifo_full` is high when a group completes, no write takes place and `overflow` becomes 1. `overflow` then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk_in | input | 1 | Asynchronous pixel clock from the source |
| hsync_in | input | 1 | Asynchronous horizontal sync |
| vsync_in | input | 1 | Asynchronous vertical sync |
| pix_in | input | 5 | Colour and intensity bits of the current pixel |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | Write strobe for the FIFO, one cycle per word |
| fifo_data | output | 31 | Packed word: address, three pixels |
| overflow | output | 1 | Sticky flag: a word was dropped on full |
| line_num | output | 9 | Current line within the frame |
| col_num | output | 9 | Current column within the line |

## Verification
The assertions check four behaviours on every cycle. They check that a write never follows a full indication and that the overflow flag never clears. They check that write strobes and filtered pixel edges are single-cycle pulses. They also check that the filtered sync edges reset the line and column counters and that filtered pixel edges advance the column counter. Only the bench scenarios can show the points that depend on the source's own waveforms. These are the rejection of short spikes, the exact packing of the pixel values and addresses, the dropping of partial groups at a line end, and the address restart after a vertical sync.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    localparam int PIX_W        = 5;
    localparam int ADDR_W       = 16;
    localparam int PIX_PER_WORD = 3;
    localparam int WORD_W       = ADDR_W + PIX_W * PIX_PER_WORD;
    localparam int GRP_CNT_W    = $clog2(PIX_PER_WORD);

    typedef logic [PIX_W-1:0]  pixel_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Earliest pixel sits in the lowest slot.
    typedef struct packed {
        addr_t                         addr;
        pixel_t [PIX_PER_WORD-1:0]     pix;
    } cap_word_t;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    function automatic cap_word_t build_word(addr_t a,
                                             pixel_t [PIX_PER_WORD-1:0] held,
                                             pixel_t last);
        cap_word_t w;
        w.addr = a;
        w.pix  = held;
        w.pix[PIX_PER_WORD-1] = last;
        return w;
    endfunction
endpackage

// File: rtl/vcap_glitch_filter.sv
module vcap_glitch_filter #(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0]   sync_q;
    logic [STABLE_CYCLES-2:0] hist_q;
    logic [STABLE_CYCLES-1:0] window;
    logic                     filt_q;

    assign window = {hist_q, sync_q[SYNC_STAGES-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            hist_q[0] <= sync_q[SYNC_STAGES-1];
            for (int j = 1; j < STABLE_CYCLES - 1; j++) begin
                hist_q[j] <= hist_q[j-1];
            end
            if (&window) begin
                filt_q <= 1'b1;
            end else if (~|window) begin
                filt_q <= 1'b0;
            end
        end
    end

    assign dout = filt_q;
endmodule

// File: rtl/vcap_edge_detect.sv
module vcap_edge_detect
    import vcap_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= 1'b0;
        end else begin
            level_d <= level;
        end
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign pulse = level & ~level_d;
        end else begin : g_fall
            assign pulse = ~level & level_d;
        end
    endgenerate
endmodule

// File: rtl/vcap_bus_sync.sv
module vcap_bus_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/vcap_packer.sv
module vcap_packer
    import vcap_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int LINE_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pix_rise,
    input  logic                hs_fall,
    input  logic                vs_fall,
    input  pixel_t              pix_data,
    input  logic                fifo_full,
    output logic                fifo_wr,
    output logic [WORD_W-1:0]   fifo_data,
    output logic                overflow,
    output logic [LINE_W-1:0]   line_num,
    output logic [COL_W-1:0]    col_num
);
    localparam logic [GRP_CNT_W-1:0] LAST_SLOT = GRP_CNT_W'(PIX_PER_WORD - 1);

    addr_t                      addr_q;
    addr_t                      grp_addr_q;
    logic [GRP_CNT_W-1:0]       slot_q;
    pixel_t [PIX_PER_WORD-1:0]  hold_q;
    logic [COL_W-1:0]           col_q;
    logic [LINE_W-1:0]          line_q;
    logic                       wr_q;
    logic                       ovf_q;
    cap_word_t                  data_q;
    cap_word_t                  next_word;
    addr_t                      word_addr;

    assign word_addr = (slot_q == '0) ? addr_q : grp_addr_q;

    always_comb begin
        next_word = build_word(word_addr, hold_q, pix_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            grp_addr_q <= '0;
            slot_q     <= '0;
            hold_q     <= '0;
            col_q      <= '0;
            line_q     <= '0;
            wr_q       <= 1'b0;
            ovf_q      <= 1'b0;
            data_q     <= '0;
        end else begin
            wr_q <= 1'b0;
            if (vs_fall) begin
                addr_q <= '0;
                line_q <= '0;
                col_q  <= '0;
                slot_q <= '0;
            end else if (hs_fall) begin
                col_q  <= '0;
                slot_q <= '0;
                line_q <= line_q + 1'b1;
            end else if (pix_rise) begin
                addr_q         <= addr_q + 1'b1;
                col_q          <= col_q + 1'b1;
                hold_q[slot_q] <= pix_data;
                if (slot_q == '0) begin
                    grp_addr_q <= addr_q;
                end
                if (slot_q == LAST_SLOT) begin
                    slot_q <= '0;
                    if (fifo_full) begin
                        ovf_q <= 1'b1;
                    end else begin
                        wr_q   <= 1'b1;
                        data_q <= next_word;
                    end
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign fifo_wr   = wr_q;
    assign fifo_data = data_q;
    assign overflow  = ovf_q;
    assign line_num  = line_q;
    assign col_num   = col_q;
endmodule

// File: rtl/vcap_frontend.sv
module vcap_frontend
    import vcap_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 3,
    parameter int COL_W         = 9,
    parameter int LINE_W        = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_clk_in,
    input  logic               hsync_in,
    input  logic               vsync_in,
    input  logic [PIX_W-1:0]   pix_in,
    input  logic               fifo_full,
    output logic               fifo_wr,
    output logic [WORD_W-1:0]  fifo_data,
    output logic               overflow,
    output logic [LINE_W-1:0]  line_num,
    output logic [COL_W-1:0]   col_num
);
    localparam int NUM_CTRL = 3;
    localparam edge_kind_e KINDS [NUM_CTRL] = '{EDGE_RISE, EDGE_FALL, EDGE_FALL};

    logic [NUM_CTRL-1:0] raw_ctrl;
    logic [NUM_CTRL-1:0] filt_ctrl;
    logic [NUM_CTRL-1:0] ctrl_pulse;
    logic                pix_rise;
    logic                hs_fall;
    logic                vs_fall;
    pixel_t              pix_synced;

    assign raw_ctrl = {vsync_in, hsync_in, pix_clk_in};

    generate
        for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
            vcap_glitch_filter #(
                .SYNC_STAGES  (SYNC_STAGES),
                .STABLE_CYCLES(STABLE_CYCLES)
            ) u_filt (
                .clk (clk),
                .rst (rst),
                .din (raw_ctrl[g]),
                .dout(filt_ctrl[g])
            );
            vcap_edge_detect #(
                .KIND(KINDS[g])
            ) u_edge (
                .clk  (clk),
                .rst  (rst),
                .level(filt_ctrl[g]),
                .pulse(ctrl_pulse[g])
            );
        end
    endgenerate

    assign pix_rise = ctrl_pulse[0];
    assign hs_fall  = ctrl_pulse[1];
    assign vs_fall  = ctrl_pulse[2];

    vcap_bus_sync #(
        .WIDTH (PIX_W),
        .STAGES(SYNC_STAGES)
    ) u_pix_sync (
        .clk (clk),
        .rst (rst),
        .din (pix_in),
        .dout(pix_synced)
    );

    vcap_packer #(
        .COL_W (COL_W),
        .LINE_W(LINE_W)
    ) u_packer (
        .clk      (clk),
        .rst      (rst),
        .pix_rise (pix_rise),
        .hs_fall  (hs_fall),
        .vs_fall  (vs_fall),
        .pix_data (pix_synced),
        .fifo_full(fifo_full),
        .fifo_wr  (fifo_wr),
        .fifo_data(fifo_data),
        .overflow (overflow),
        .line_num (line_num),
        .col_num  (col_num)
    );
endmodule

// File: rtl/vcap_frontend_chk.sv
module vcap_frontend_chk #(
    parameter int COL_W  = 9,
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic              overflow,
    input logic [LINE_W-1:0] line_num,
    input logic [COL_W-1:0]  col_num,
    input logic              pix_rise,
    input logic              hs_fall,
    input logic              vs_fall
);
    // R8: no write follows a full indication
    assert_no_write_on_full_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !$past(fifo_full));

    // R8: overflow is sticky
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: write strobe lasts one cycle
    assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> !fifo_wr);

    // R2: a filtered pixel edge is a one-cycle pulse
    assert_single_pix_edge_R2: assert property (@(posedge clk) disable iff (rst)
        pix_rise |=> !pix_rise);

    // R3: vertical sync edge clears the position
    assert_frame_reset_R3: assert property (@(posedge clk) disable iff (rst)
        vs_fall |=> (line_num == '0) && (col_num == '0));

    // R4: horizontal sync edge clears the column
    assert_line_reset_R4: assert property (@(posedge clk) disable iff (rst)
        (hs_fall && !vs_fall) |=> (col_num == '0));

    // R5: a pixel edge advances the column by one
    assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
        (pix_rise && !hs_fall && !vs_fall) |=>
            (COL_W'(col_num - $past(col_num)) == COL_W'(1)));
endmodule

bind vcap_frontend vcap_frontend_chk #(
    .COL_W (COL_W),
    .LINE_W(LINE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_full(fifo_full),
    .fifo_wr  (fifo_wr),
    .overflow (overflow),
    .line_num (line_num),
    .col_num  (col_num),
    .pix_rise (pix_rise),
    .hs_fall  (hs_fall),
    .vs_fall  (vs_fall)
);

// File: tb/vcap_frontend_tb.sv
`timescale 1ns/1ps
module vcap_frontend_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_clk_in = 1'b0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic [4:0]  pix_in = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [30:0] fifo_data;
    logic        overflow;
    logic [8:0]  line_num;
    logic [8:0]  col_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vcap_frontend u_dut (
        .clk(clk), .rst(rst), .pix_clk_in(pix_clk_in), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .pix_in(pix_in), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .overflow(overflow),
        .line_num(line_num), .col_num(col_num)
    );

    // captured and expected words
    logic [30:0] got_w [0:255];
    logic [30:0] exp_w [0:255];
    int n_got = 0;
    int n_exp = 0;
    int n_cmp = 0;
    int wr_len = 0;
    int long_wr = 0;

    always @(negedge clk) begin
        if (fifo_wr) begin
            if (n_got < 256) got_w[n_got] = fifo_data;
            n_got++;
            wr_len++;
            if (wr_len > 1) long_wr++;
        end else begin
            wr_len = 0;
        end
    end

    // bench model
    int m_addr = 0, m_col = 0, m_line = 0, m_slot = 0, m_grp = 0;
    logic [4:0] m_hold [0:2];

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_pixel(logic [4:0] v);
        pix_in = v;
        wait_cyc(2);
        pix_clk_in = 1'b1;
        wait_cyc(10);
        pix_clk_in = 1'b0;
        wait_cyc(10);
        m_hold[m_slot] = v;
        if (m_slot == 0) m_grp = m_addr;
        m_addr = (m_addr + 1) % 65536;
        m_col++;
        if (m_slot == 2) begin
            m_slot = 0;
            if (!fifo_full && n_exp < 256) begin
                exp_w[n_exp] = {m_grp[15:0], m_hold[2], m_hold[1], m_hold[0]};
                n_exp++;
            end
        end else begin
            m_slot++;
        end
    endtask

    task automatic hsync_pulse();
        hsync_in = 1'b1;
        wait_cyc(10);
        hsync_in = 1'b0;
        wait_cyc(10);
        m_col = 0; m_slot = 0; m_line++;
    endtask

    task automatic vsync_pulse();
        vsync_in = 1'b1;
        wait_cyc(10);
        vsync_in = 1'b0;
        wait_cyc(10);
        m_col = 0; m_slot = 0; m_line = 0; m_addr = 0;
    endtask

    task automatic cmp_words(string req);
        chk(req, "word count", n_got, n_exp);
        while (n_cmp < n_exp && n_cmp < n_got) begin
            chk(req, $sformatf("word %0d", n_cmp), int'(got_w[n_cmp]), int'(exp_w[n_cmp]));
            n_cmp++;
        end
    endtask

    task automatic chk_pos(string req);
        chk(req, "col_num", int'(col_num), m_col);
        chk(req, "line_num", int'(line_num), m_line);
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        // R1 reset state
        chk("R1", "fifo_wr", int'(fifo_wr), 0);
        chk("R1", "overflow", int'(overflow), 0);
        chk("R1", "line_num", int'(line_num), 0);
        chk("R1", "col_num", int'(col_num), 0);

        // R3 frame start, R5/R6 packing with partial tail
        vsync_pulse();
        chk_pos("R3");
        for (int i = 0; i < 7; i++) send_pixel(5'(i * 3 + 1));
        chk_pos("R5");
        cmp_words("R6");

        // R4 line end discards partial group; addresses continue
        hsync_pulse();
        chk_pos("R4");
        for (int i = 0; i < 6; i++) send_pixel(5'(31 - i));
        cmp_words("R4");

        // R2 short spikes on the pixel clock are ignored
        pix_clk_in = 1'b1; wait_cyc(1); pix_clk_in = 1'b0; wait_cyc(10);
        pix_clk_in = 1'b1; wait_cyc(2); pix_clk_in = 1'b0; wait_cyc(10);
        chk_pos("R2");
        chk("R2", "no word from spike", n_got, n_exp);
        // R2 short spike on hsync ignored
        hsync_in = 1'b1; wait_cyc(2); hsync_in = 1'b0; wait_cyc(10);
        chk_pos("R2");

        // exhaustive pixel value sweep over a line
        hsync_pulse();
        for (int i = 0; i < 33; i++) send_pixel(5'(i));
        chk_pos("R5");
        cmp_words("R6");
        hsync_pulse();
        for (int i = 0; i < 33; i++) send_pixel(5'((i * 13 + 7) % 32));
        cmp_words("R6");

        // R8 overflow on full
        hsync_pulse();
        fifo_full = 1'b1;
        for (int i = 0; i < 3; i++) send_pixel(5'(i + 9));
        chk("R8", "overflow set", int'(overflow), 1);
        cmp_words("R8");
        fifo_full = 1'b0;
        for (int i = 0; i < 3; i++) send_pixel(5'(i + 20));
        cmp_words("R8");
        chk("R8", "overflow sticky", int'(overflow), 1);

        // R3 new frame restarts address at 0
        vsync_pulse();
        chk_pos("R3");
        for (int i = 0; i < 3; i++) send_pixel(5'(i + 4));
        cmp_words("R3");
        chk("R3", "first address", int'(got_w[n_got-1][30:15]), 0);

        // R7 each write lasts one cycle
        chk("R7", "long write pulses", long_wr, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule